// File: doc/BRIEF.md
# Memory Semaphore Wait Comparator

This block executes one semaphore-wait command taken from a command stream. It accepts a header dword, decodes the command fields, and then takes the payload dwords. The payload is an inline comparison value and a 64-bit semaphore address, split into a low dword and a high dword. The token form of the command carries one further trailing dword. Once the payload is in, the block reads the semaphore through a simple request/response read port. It then compares the returned 32-bit value with the inline value under one of six unsigned relational modes.

When the condition holds, the block pulses `done` and accepts the next command. When the condition fails, the next step depends on the header. In poll mode the block waits a programmable interval and reads again. In the other mode it sleeps until an external wake pulse and then reads again. The read request carries several sideband tags: the address-space select, the register-poll select and, in the token form, the token. The read address is always put into canonical form by sign-extending it from bit 47.

A header that the block does not recognise ends the command at once with an error. A relational mode code the block does not define also ends the command with an error, after the payload has been taken and without any read.

Top module: `sem_wait_unit`

## Requirements
- R1: A header is accepted only when its bits 31:29 are 0, its bits 28:23 equal 0x1C, and its length field in bits 4:0 is 2 (basic form, three payload dwords: inline value, address low, address high) or 3 (token form, four payload dwords). Any other header ends the command one cycle after it is accepted, with `done` and `errOut` both high, no read issued and no payload taken.
- R2: The mode field in header bits 14:12 selects an unsigned 32-bit comparison of the memory value M against the inline value V: 0 is M>V, 1 is M>=V, 2 is M<V, 3 is M<=V, 4 is M==V, 5 is M!=V. A response that meets the condition produces a `done` pulse with `errOut` low in the cycle after the response.
- R3: Mode codes 6 and 7 end the command in the cycle after the last payload dword, with `done` and `errOut` high and no read request.
- R4: With header bit 15 set, a failing response leads to a new read request exactly E cycles after the response cycle. E is `pollInterval`, or 4 when `pollInterval` is below 4.
- R5: With header bit 15 clear, a failing response puts the block to sleep, and it issues no read until `wakeIn` is seen. The next read request follows one cycle after the wake pulse.
- R6: `rdAddr` equals the captured 64-bit address with bits 63:48 replaced by copies of bit 47.
- R7: During a read request, `rdGlobal` reflects header bit 22 and `rdReg` reflects header bit 16. `rdToken` carries header bits 9:5 in the token form and is zero in the basic form.
- R8: `done` lasts exactly one cycle, and `errOut` is high only together with `done`. `inReady` is high only while the block is idle or taking payload, so no header is accepted while a command is in progress.
- R9: After reset, `inReady` is 1 and `rdReq`, `done` and `errOut` are 0.
- R10: The trailing dword of the token form is consumed and has no effect. The read address and tags are unchanged by it, and it is never decoded as a header.
- R11: The first read request is asserted in the cycle after the last payload dword is accepted, and each read request lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Command dword valid |
| inData | input | 32 | Command dword |
| inReady | output | 1 | Block can take a command dword |
| rdReq | output | 1 | One-cycle read request |
| rdAddr | output | 64 | Canonical read address |
| rdGlobal | output | 1 | Address-space select tag |
| rdReg | output | 1 | Register-poll select tag |
| rdToken | output | 5 | Token tag (zero in basic form) |
| rdRespValid | input | 1 | Read response valid |
| rdRespData | input | 32 | Read response value |
| wakeIn | input | 1 | Wake pulse for sleep mode |
| pollInterval | input | GAP_W | Poll spacing in cycles (minimum 4 applied) |
| done | output | 1 | One-cycle completion pulse |
| errOut | output | 1 | Error, valid with done |

## Verification
The bench builds the block with `GAP_W = 4`. With that width every value of `pollInterval` can be swept, including the values below the floor of 4 and the top value of 15, so the poll spacing is checked for each of them. All six relational modes are run against memory values just below, equal to and just above two inline values. One of the inline values is 0x80000000, which separates an unsigned comparison from a signed one. The runs alternate between poll and wake re-evaluation, and between addresses with bit 47 clear and set. Illegal mode codes, malformed headers and the token form's trailing dword are each run as well.

// File: rtl/sem_wait_pkg.sv
package sem_wait_pkg;

  // header field positions and codes
  localparam int HdrClientHi  = 31;
  localparam int HdrClientLo  = 29;
  localparam int HdrOpcHi     = 28;
  localparam int HdrOpcLo     = 23;
  localparam int HdrGlobalBit = 22;
  localparam int HdrRegBit    = 16;
  localparam int HdrPollBit   = 15;
  localparam int HdrModeHi    = 14;
  localparam int HdrModeLo    = 12;
  localparam int HdrTokLo     = 5;
  localparam int HdrLenHi     = 4;

  localparam logic [5:0] SemOpcode = 6'h1C;
  localparam logic [4:0] LenBasic  = 5'd2;
  localparam logic [4:0] LenToken  = 5'd3;

  typedef enum logic [2:0] {
    CMP_GT = 3'd0,
    CMP_GE = 3'd1,
    CMP_LT = 3'd2,
    CMP_LE = 3'd3,
    CMP_EQ = 3'd4,
    CMP_NE = 3'd5
  } cmpMode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAYLOAD,
    ST_ISSUE,
    ST_WAIT,
    ST_GAP,
    ST_SLEEP,
    ST_DONE
  } state_e;

  typedef struct packed {
    logic capHdr;
    logic capInline;
    logic capAddrLo;
    logic capAddrHi;
  } dpStrobe_t;

endpackage

// File: rtl/sem_wait_dp.sv
module sem_wait_dp
  import sem_wait_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 64,
  parameter int CANON_BIT = 47,
  parameter int TOK_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] inData,
  input  logic [DATA_W-1:0] respData,
  output logic              hdrOk,
  output logic              hdrTokForm,
  output logic              modeLegal,
  output logic              pollEn,
  output logic              condMet,
  output logic              rdGlobal,
  output logic              rdReg,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [TOK_W-1:0]  rdToken
);

  localparam int AddrHiW = ADDR_W - DATA_W;
  localparam int ExtW    = ADDR_W - 1 - CANON_BIT;
  localparam int TokHi   = HdrTokLo + TOK_W - 1;

  logic [2:0]        modeReg;
  logic              pollReg, globReg, regReg;
  logic [TOK_W-1:0]  tokReg;
  logic [DATA_W-1:0] inlReg;
  logic [ADDR_W-1:0] addrReg;

  // header decode straight from the incoming dword
  logic [4:0] lenField;
  logic       clientOk, opcOk;
  always_comb begin
    lenField   = inData[HdrLenHi:0];
    clientOk   = (inData[HdrClientHi:HdrClientLo] == 3'd0);
    opcOk      = (inData[HdrOpcHi:HdrOpcLo] == SemOpcode);
    hdrTokForm = (lenField == LenToken);
    hdrOk      = clientOk && opcOk && ((lenField == LenBasic) || (lenField == LenToken));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      pollReg <= 1'b0;
      globReg <= 1'b0;
      regReg  <= 1'b0;
      tokReg  <= '0;
      inlReg  <= '0;
      addrReg <= '0;
    end else begin
      if (strb.capHdr) begin
        modeReg <= inData[HdrModeHi:HdrModeLo];
        pollReg <= inData[HdrPollBit];
        globReg <= inData[HdrGlobalBit];
        regReg  <= inData[HdrRegBit];
        tokReg  <= hdrTokForm ? inData[TokHi:HdrTokLo] : '0;
      end
      if (strb.capInline) inlReg <= inData;
      if (strb.capAddrLo) addrReg[DATA_W-1:0] <= inData;
      if (strb.capAddrHi) addrReg[ADDR_W-1:DATA_W] <= inData[AddrHiW-1:0];
    end
  end

  // unsigned relational compare of memory value against inline value
  always_comb begin
    case (modeReg)
      CMP_GT:  condMet = (respData >  inlReg);
      CMP_GE:  condMet = (respData >= inlReg);
      CMP_LT:  condMet = (respData <  inlReg);
      CMP_LE:  condMet = (respData <= inlReg);
      CMP_EQ:  condMet = (respData == inlReg);
      CMP_NE:  condMet = (respData != inlReg);
      default: condMet = 1'b0;
    endcase
  end

  assign modeLegal = (modeReg <= 3'd5);
  assign pollEn    = pollReg;
  assign rdGlobal  = globReg;
  assign rdReg     = regReg;
  assign rdToken   = tokReg;

  // canonical form: replicate the top meaningful bit upward
  generate
    if (ExtW > 0) begin : g_ext
      assign rdAddr = {{ExtW{addrReg[CANON_BIT]}}, addrReg[CANON_BIT:0]};
    end else begin : g_noext
      assign rdAddr = addrReg;
    end
  endgenerate

  AST_ADDR_CANON: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(rdAddr[ADDR_W-1:CANON_BIT]) == 0) ||
    ($countones(rdAddr[ADDR_W-1:CANON_BIT]) == ADDR_W - CANON_BIT)); // R6

endmodule

// File: rtl/sem_wait_ctrl.sv
module sem_wait_ctrl
  import sem_wait_pkg::*;
#(
  parameter int GAP_W   = 8,
  parameter int MIN_GAP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             hdrOk,
  input  logic             hdrTokForm,
  input  logic             modeLegal,
  input  logic             pollEn,
  input  logic             condMet,
  input  logic             rdRespValid,
  input  logic             wakeIn,
  input  logic [GAP_W-1:0] pollInterval,
  output logic             inReady,
  output dpStrobe_t        strb,
  output logic             rdReq,
  output logic             done,
  output logic             errOut
);

  localparam logic [GAP_W-1:0] MinGapV = GAP_W'(MIN_GAP);
  localparam logic [GAP_W-1:0] TwoV    = GAP_W'(2);

  state_e           state, stateNxt;
  logic [1:0]       idx;
  logic             tokFormReg;
  logic             errReg, errSet;
  logic [GAP_W-1:0] gapCnt;
  logic [GAP_W-1:0] effGap;
  logic [1:0]       lastIdx;
  logic             gapLoad;

  assign effGap  = (pollInterval < MinGapV) ? MinGapV : pollInterval;
  assign lastIdx = tokFormReg ? 2'd3 : 2'd2;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    errSet   = 1'b0;
    gapLoad  = 1'b0;
    case (state)
      ST_IDLE: if (inValid) begin
        strb.capHdr = 1'b1;
        if (hdrOk) stateNxt = ST_PAYLOAD;
        else begin
          stateNxt = ST_DONE;
          errSet   = 1'b1;
        end
      end
      ST_PAYLOAD: if (inValid) begin
        strb.capInline = (idx == 2'd0);
        strb.capAddrLo = (idx == 2'd1);
        strb.capAddrHi = (idx == 2'd2);
        if (idx == lastIdx) begin
          if (modeLegal) stateNxt = ST_ISSUE;
          else begin
            stateNxt = ST_DONE;
            errSet   = 1'b1;
          end
        end
      end
      ST_ISSUE: stateNxt = ST_WAIT;
      ST_WAIT: if (rdRespValid) begin
        if (condMet) stateNxt = ST_DONE;
        else if (pollEn) begin
          stateNxt = ST_GAP;
          gapLoad  = 1'b1;
        end else stateNxt = ST_SLEEP;
      end
      ST_GAP:   if (gapCnt == '0) stateNxt = ST_ISSUE;
      ST_SLEEP: if (wakeIn) stateNxt = ST_ISSUE;
      ST_DONE:  stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      idx        <= '0;
      tokFormReg <= 1'b0;
      errReg     <= 1'b0;
      gapCnt     <= '0;
    end else begin
      state <= stateNxt;
      if (strb.capHdr) begin
        idx        <= '0;
        tokFormReg <= hdrTokForm;
      end else if (state == ST_PAYLOAD && inValid) begin
        idx <= idx + 2'd1;
      end
      if (errSet) errReg <= 1'b1;
      else if (state == ST_DONE) errReg <= 1'b0;
      if (gapLoad) gapCnt <= effGap - TwoV;
      else if (state == ST_GAP && gapCnt != '0) gapCnt <= gapCnt - 1'b1;
    end
  end

  assign inReady = (state == ST_IDLE) || (state == ST_PAYLOAD);
  assign rdReq   = (state == ST_ISSUE);
  assign done    = (state == ST_DONE);
  assign errOut  = (state == ST_DONE) && errReg;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> done && !inReady); // R8
  AST_ERR_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    errReg |-> !rdReq); // R3
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && !wakeIn) |=> !rdReq); // R5
  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP && gapCnt != '0) |=> !rdReq); // R4
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq); // R11

endmodule

// File: rtl/sem_wait_unit.sv
module sem_wait_unit
  import sem_wait_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 64,
  parameter int CANON_BIT = 47,
  parameter int TOK_W     = 5,
  parameter int GAP_W     = 8,
  parameter int MIN_GAP   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdGlobal,
  output logic              rdReg,
  output logic [TOK_W-1:0]  rdToken,
  input  logic              rdRespValid,
  input  logic [DATA_W-1:0] rdRespData,
  input  logic              wakeIn,
  input  logic [GAP_W-1:0]  pollInterval,
  output logic              done,
  output logic              errOut
);

  dpStrobe_t strb;
  logic      hdrOk, hdrTokForm, modeLegal, pollEn, condMet;

  sem_wait_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CANON_BIT(CANON_BIT), .TOK_W(TOK_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData), .respData(rdRespData),
    .hdrOk(hdrOk), .hdrTokForm(hdrTokForm), .modeLegal(modeLegal), .pollEn(pollEn),
    .condMet(condMet), .rdGlobal(rdGlobal), .rdReg(rdReg), .rdAddr(rdAddr),
    .rdToken(rdToken)
  );

  sem_wait_ctrl #(
    .GAP_W(GAP_W), .MIN_GAP(MIN_GAP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .hdrOk(hdrOk),
    .hdrTokForm(hdrTokForm), .modeLegal(modeLegal), .pollEn(pollEn),
    .condMet(condMet), .rdRespValid(rdRespValid), .wakeIn(wakeIn),
    .pollInterval(pollInterval), .inReady(inReady), .strb(strb), .rdReq(rdReq),
    .done(done), .errOut(errOut)
  );

endmodule

// File: tb/sem_wait_unit_tb.sv
`timescale 1ns/1ps
module sem_wait_unit_tb;

  localparam int GW = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        inReady;
  logic        rdReq;
  logic [63:0] rdAddr;
  logic        rdGlobal, rdReg;
  logic [4:0]  rdToken;
  logic        rdRespValid = 1'b0;
  logic [31:0] rdRespData = '0;
  logic        wakeIn = 1'b0;
  logic [GW-1:0] pollInterval = '0;
  logic        done, errOut;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sem_wait_unit #(.GAP_W(GW)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdGlobal(rdGlobal), .rdReg(rdReg),
    .rdToken(rdToken), .rdRespValid(rdRespValid), .rdRespData(rdRespData),
    .wakeIn(wakeIn), .pollInterval(pollInterval), .done(done), .errOut(errOut)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit expCond(input int m, input logic [31:0] a, input logic [31:0] b);
    case (m)
      0: return a > b;
      1: return a >= b;
      2: return a < b;
      3: return a <= b;
      4: return a == b;
      default: return a != b;
    endcase
  endfunction

  function automatic logic [31:0] mkHdr(input int mode, input bit poll, input bit rsel,
                                        input bit glob, input bit tokForm, input logic [4:0] tok);
    logic [31:0] h;
    h = (32'h1C << 23) | (32'(glob) << 22) | (32'(rsel) << 16) | (32'(poll) << 15) |
        (32'(mode) << 12) | (tokForm ? (32'(tok) << 5) | 32'd3 : 32'd2);
    return h;
  endfunction

  logic [31:0] wbuf [0:4];

  // drive nWords dwords; returns at the negedge after the last one is taken
  task automatic sendWords(input int nWords);
    for (int i = 0; i < nWords; i++) begin
      @(negedge clk);
      chk(inReady == 1'b1, "R8", "inReady while taking command", 64'(inReady), 64'd1);
      inValid = 1'b1;
      inData  = wbuf[i];
    end
    @(negedge clk);
    inValid = 1'b0;
    inData  = '0;
  endtask

  // at a negedge with rdReq high: return a value, end at the negedge after it is consumed
  task automatic respond(input logic [31:0] v);
    @(negedge clk);
    chk(inReady == 1'b0, "R8", "inReady low while reading", 64'(inReady), 64'd0);
    rdRespValid = 1'b1;
    rdRespData  = v;
    @(negedge clk);
    rdRespValid = 1'b0;
  endtask

  task automatic expectDoneOk(input string req);
    chk(done == 1'b1 && errOut == 1'b0, req, "done without error",
        {62'd0, done, errOut}, 64'd2);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done single cycle", 64'(done), 64'd0);
  endtask

  task automatic runWait(input int mode, input bit poll, input bit rsel, input bit glob,
                         input bit tokForm, input logic [4:0] tok, input logic [31:0] inl,
                         input logic [63:0] addr, input logic [31:0] first,
                         input logic [31:0] pass, input int interval);
    logic [63:0] expAddr;
    int eff, n;
    expAddr = {{16{addr[47]}}, addr[47:0]};
    pollInterval = GW'(interval);
    wbuf[0] = mkHdr(mode, poll, rsel, glob, tokForm, tok);
    wbuf[1] = inl;
    wbuf[2] = addr[31:0];
    wbuf[3] = addr[63:32];
    wbuf[4] = mkHdr(4, 0, 0, 0, 0, 5'd0); // R10: trailing dword looks like a header
    sendWords(tokForm ? 5 : 4);
    chk(rdReq == 1'b1, "R11", "read follows last payload", 64'(rdReq), 64'd1);
    chk(rdAddr == expAddr, "R6", "canonical address", rdAddr, expAddr);
    chk(rdGlobal == glob && rdReg == rsel, "R7", "global/reg tags",
        {62'd0, rdGlobal, rdReg}, {62'd0, glob, rsel});
    chk(rdToken == (tokForm ? tok : 5'd0), "R7", "token tag", 64'(rdToken),
        64'(tokForm ? tok : 5'd0));
    respond(first);
    if (expCond(mode, first, inl)) begin
      expectDoneOk("R2");
    end else begin
      chk(done == 1'b0 && rdReq == 1'b0, "R2", "failing compare holds",
          {62'd0, done, rdReq}, 64'd0);
      if (poll) begin
        eff = (interval < 4) ? 4 : interval;
        n = 0;
        while (!rdReq && n < 40) begin
          @(negedge clk);
          n++;
        end
        chk(n == eff - 1, "R4", "poll spacing", 64'(n + 1), 64'(eff));
      end else begin
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk(rdReq == 1'b0, "R5", "no read while asleep", 64'(rdReq), 64'd0);
        end
        wakeIn = 1'b1;
        @(negedge clk);
        wakeIn = 1'b0;
        chk(rdReq == 1'b1, "R5", "read after wake", 64'(rdReq), 64'd1);
      end
      chk(rdAddr == expAddr, "R10", "address stable on re-read", rdAddr, expAddr);
      respond(pass);
      expectDoneOk("R2");
    end
  endtask

  task automatic runErr(input logic [31:0] hdr, input int nWords, input string req);
    wbuf[0] = hdr;
    wbuf[1] = 32'h11;
    wbuf[2] = 32'h22;
    wbuf[3] = 32'h33;
    sendWords(nWords);
    chk(done == 1'b1 && errOut == 1'b1 && rdReq == 1'b0, req, "error completion",
        {61'd0, done, errOut, rdReq}, 64'd6);
    chk(inReady == 1'b0, "R8", "no header taken while done", 64'(inReady), 64'd0);
    @(negedge clk);
    chk(done == 1'b0 && errOut == 1'b0, "R8", "error pulse ends",
        {62'd0, done, errOut}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [31:0] inls [0:1];
    logic [31:0] mv, first, pass;
    logic [63:0] addr;
    int cnt;
    inls[0] = 32'd100;
    inls[1] = 32'h8000_0000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(inReady == 1'b1 && rdReq == 1'b0 && done == 1'b0 && errOut == 1'b0, "R9",
        "reset state", {60'd0, inReady, rdReq, done, errOut}, 64'h8);

    // six modes x three relations x two inline values
    cnt = 0;
    for (int m = 0; m < 6; m++) begin
      for (int iv = 0; iv < 2; iv++) begin
        for (int r = 0; r < 3; r++) begin
          first = inls[iv] + 32'(r) - 32'd1;
          pass = first;
          for (int p = 0; p < 3; p++) begin
            mv = inls[iv] + 32'(p) - 32'd1;
            if (expCond(m, mv, inls[iv]) && !expCond(m, pass, inls[iv])) pass = mv;
          end
          addr = cnt[0] ? 64'h0000_8000_1234_5678 : 64'h5A5A_7FFF_0000_0040;
          runWait(m, cnt[1], cnt[2], cnt[0], 1'b0, 5'd0, inls[iv], addr,
                  first, pass, 5);
          cnt++;
        end
      end
    end

    // poll spacing across every interval value
    for (int i = 0; i < 16; i++) begin
      runWait(4, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 32'd7, 64'h0000_0000_0000_1000,
              32'd6, 32'd7, i);
    end

    // token form, wake and poll
    runWait(5, 1'b0, 1'b1, 1'b1, 1'b1, 5'h15, 32'd9, 64'hFFFF_8ABC_DEF0_0008,
            32'd9, 32'd3, 4);
    runWait(0, 1'b1, 1'b0, 1'b0, 1'b1, 5'h0A, 32'd9, 64'h1234_0001_0000_0010,
            32'd9, 32'd10, 6);
    // basic command straight after a token command
    runWait(4, 1'b0, 1'b0, 1'b0, 1'b0, 5'h1F, 32'd1, 64'h0, 32'd1, 32'd1, 4);

    // illegal modes
    runErr(mkHdr(6, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0), 4, "R3");
    runErr(mkHdr(7, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0), 4, "R3");
    // malformed headers
    runErr((32'h1B << 23) | 32'd2, 1, "R1");
    runErr((32'h1 << 29) | (32'h1C << 23) | 32'd2, 1, "R1");
    runErr((32'h1C << 23) | 32'd4, 1, "R1");
    @(negedge clk);
    chk(inReady == 1'b1 && rdReq == 1'b0, "R1", "idle after errors",
        {62'd0, inReady, rdReq}, 64'd2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule